// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block turns synchronous host requests into the strobe and address sequences of one asynchronous EDO DRAM bank. The data path is 72 bits wide. A host uses a valid/ready port that carries a read/write flag, a row address, a column address and write data. Read data comes back on a separate one-cycle valid pulse. The controller opens a row with a RAS activation. It then runs one CAS cycle per access. Later requests to the same row reuse the open row as EDO page-mode cycles.

Writes are always early writes. The write strobe falls before the column strobe, and the output enable stays high throughout, so the memory's data pins never drive. An external scheduler asks for refresh through a level request with a mode bit. The controller can run a CAS-before-RAS refresh, or a RAS-only refresh that drives a supplied row. A refresh is granted only while the controller is idle. A pending refresh closes an open row and wins over a waiting host request.

Every DRAM timing minimum is a parameter counted in clock cycles. The parameters must satisfy T_RCD ≥ T_RAH + T_ASC, T_CAP ≤ T_CAS and T_RAS_MIN > T_CHR.

Top module: `edo_dram_ctrl`

## Requirements
- R1: During reset and right after it, ras_n, cas_n, we_n and oe_n are high, dq_oe and rd_valid are low, and req_ready is high while no refresh is requested.
- R2: The row address is on addr for at least T_ASR cycles before ras_n falls for an access, and stays there for T_RAH cycles after the fall.
- R3: The first cas_n fall of an activation comes between T_RCD and T_RCD_MAX cycles after ras_n falls. The column address is on addr for at least T_ASC cycles before every cas_n fall.
- R4: ras_n stays high for at least T_RP cycles before every fall, and stays low for at least T_RAS_MIN cycles in every activation.
- R5: A request to the row that is already open is served without closing it. Each CAS pulse lasts at least T_CAS cycles, with at least T_CP high cycles between pulses. After an access with no further request, the row stays open.
- R6: A request to a different row closes the open row, precharges, and opens the new row before its column cycle.
- R7: A write drives we_n low at least one cycle before cas_n falls, drives dq_oe with the write data while we_n is low, and keeps oe_n high whenever we_n is low.
- R8: A read holds oe_n low during its CAS pulse. It samples dq_in in the T_CAP-th cycle of that pulse and returns the value on rd_data with a one-cycle rd_valid pulse. Reads return in request order.
- R9: A refresh with ref_ras_only=0 drops cas_n at least T_CSR cycles before ras_n falls, keeps we_n high at that fall, and keeps cas_n low for at least T_CHR cycles after it.
- R10: A refresh with ref_ras_only=1 keeps cas_n high throughout, and keeps ref_row on addr for the whole RAS low time.
- R11: When ref_req and req_valid are both high while idle, ref_grant is high and req_ready is low, and the refresh runs first. A refresh request that arrives while a row is open closes that row and then runs.
- R12: No activation keeps ras_n low for more than T_RAS_MAX cycles. A long same-row burst is split over several activations, and an idle open row is closed by that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | AW | Row address |
| req_col | input | AW | Column address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse with returned read data |
| rd_data | output | DW | Read data |
| ref_req | input | 1 | Refresh request, held until granted |
| ref_ras_only | input | 1 | 1 = RAS-only refresh, 0 = CAS-before-RAS |
| ref_row | input | AW | Row to refresh in RAS-only mode |
| ref_grant | output | 1 | Refresh accepted this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | AW | Multiplexed row/column address |
| dq_out | output | DW | Write data toward the memory |
| dq_oe | output | 1 | Controller drives dq_out onto the data pins |
| dq_in | input | DW | Data from the memory |

## Verification
The bench writes and reads every cell of a small array. It does so in two ways: long same-row bursts, which must be cut by the RAS-low limit, and a pattern that switches rows on every access, which must close and reopen rows. A design that let the address change at the same edge as a strobe would fail the setup and hold counts. One that kept a row open past the limit, or that reused a stale row after a change of row, would read back wrong data. One that let oe_n fall during a write, or dropped we_n only as CAS fell, would corrupt the write or break the early-write spacing. The refresh tests check the following. A simultaneous refresh and host request must go to the refresh first. A refresh raised while a row is open must close that row. The CAS-before-RAS and RAS-only forms must be told apart by the strobe order and the row held on addr.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int DW        = 72,
  parameter int AW        = 12,
  parameter int T_ASR     = 1,
  parameter int T_RAH     = 1,
  parameter int T_ASC     = 1,
  parameter int T_RCD     = 2,
  parameter int T_RCD_MAX = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_CAP     = 2,
  parameter int T_RP      = 3,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 20000,
  parameter int T_CSR     = 2,
  parameter int T_CHR     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_row,
  input  logic [AW-1:0] req_col,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          ref_req,
  input  logic          ref_ras_only,
  input  logic [AW-1:0] ref_row,
  output logic          ref_grant,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  localparam int SPAN      = T_ASR + T_RAH + T_RCD + T_CAS + T_CP + T_RP + T_RAS_MIN + T_CSR + T_CHR + T_ASC;
  localparam int CW        = $clog2(SPAN + 1);
  localparam int RW        = $clog2(T_RAS_MAX + 2);
  localparam int PAGE_COST = T_ASC + T_CAS + T_CP;

  typedef enum logic [3:0] {
    S_IDLE, S_ASR, S_RCD, S_CAS, S_CP, S_OPEN, S_ASC, S_PRE,
    S_CSR, S_CHR, S_RASR, S_RFR
  } st_t;

  st_t           state, nxt;
  logic [CW-1:0] cnt, dur;
  logic [RW-1:0] ras_cnt;
  logic          op_wr, rmode;
  logic [AW-1:0] row_q, col_q, rrow_q;
  logic [DW-1:0] wdata_q;
  logic          done, page_hit, may_close, close_row, accept, ras_low, wr_phase;

  assign done      = (cnt == dur - CW'(1));
  assign page_hit  = state == S_OPEN && req_valid && req_row == row_q && !ref_req &&
                     (int'(ras_cnt) + PAGE_COST + 2 <= T_RAS_MAX);
  assign may_close = int'(ras_cnt) + 1 >= T_RAS_MIN;
  assign close_row = may_close && (ref_req || req_valid || int'(ras_cnt) + 2 > T_RAS_MAX);
  assign req_ready = (state == S_IDLE && !ref_req) || page_hit;
  assign ref_grant = state == S_IDLE && ref_req;
  assign accept    = req_valid && req_ready;

  always_comb begin
    case (state)
      S_ASR, S_RASR: dur = CW'(T_ASR);
      S_RCD:         dur = CW'(T_RCD);
      S_CAS:         dur = CW'(T_CAS);
      S_CP:          dur = CW'(T_CP);
      S_ASC:         dur = CW'(T_ASC);
      S_PRE:         dur = CW'(T_RP);
      S_CSR:         dur = CW'(T_CSR);
      S_CHR:         dur = CW'(T_CHR);
      S_RFR:         dur = rmode ? CW'(T_RAS_MIN) : CW'(T_RAS_MIN - T_CHR);
      default:       dur = CW'(1);
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (ref_req) nxt = ref_ras_only ? S_RASR : S_CSR;
              else if (req_valid) nxt = S_ASR;
      S_ASR:  if (done) nxt = S_RCD;
      S_RCD:  if (done) nxt = S_CAS;
      S_CAS:  if (done) nxt = S_CP;
      S_CP:   if (done) nxt = S_OPEN;
      S_OPEN: if (page_hit) nxt = S_ASC;
              else if (close_row) nxt = S_PRE;
      S_ASC:  if (done) nxt = S_CAS;
      S_CSR:  if (done) nxt = S_CHR;
      S_CHR:  if (done) nxt = S_RFR;
      S_RASR: if (done) nxt = S_RFR;
      S_RFR:  if (done) nxt = S_PRE;
      S_PRE:  if (done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ras_cnt  <= '0;
      op_wr    <= 1'b0;
      rmode    <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      rrow_q   <= '0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state   <= nxt;
      cnt     <= (nxt != state || nxt == S_OPEN || nxt == S_IDLE) ? '0 : cnt + CW'(1);
      ras_cnt <= ras_low ? ras_cnt + RW'(1) : '0;
      if (ref_grant) begin
        rmode  <= ref_ras_only;
        rrow_q <= ref_row;
      end
      if (accept) begin
        op_wr   <= req_write;
        row_q   <= req_row;
        col_q   <= req_col;
        wdata_q <= req_wdata;
      end
      rd_valid <= 1'b0;
      if (state == S_CAS && !op_wr && cnt == CW'(T_CAP - 1)) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
      end
    end
  end

  assign ras_low  = state inside {S_RCD, S_CAS, S_CP, S_OPEN, S_ASC, S_CHR, S_RFR};
  assign ras_n    = !ras_low;
  assign cas_n    = !(state inside {S_CAS, S_CSR, S_CHR});
  assign wr_phase = op_wr && (state inside {S_RCD, S_ASC, S_CAS});
  assign we_n     = !wr_phase;
  assign dq_oe    = wr_phase;
  assign dq_out   = wdata_q;
  assign oe_n     = !(!op_wr && state == S_CAS);

  always_comb begin
    case (state)
      S_ASR:                     addr = row_q;
      S_RCD:                     addr = (cnt < CW'(T_RAH)) ? row_q : col_q;
      S_CAS, S_CP, S_OPEN, S_ASC: addr = col_q;
      S_RASR:                    addr = rrow_q;
      S_RFR:                     addr = rmode ? rrow_q : '0;
      default:                   addr = '0;
    endcase
  end

  p_ras_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> int'(ras_cnt) < T_RAS_MAX);
  p_ras_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> int'($past(ras_cnt)) >= T_RAS_MIN - 1);
  p_we_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));
  p_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> (we_n && $past(!cas_n)));
  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_ref_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> !req_ready);
endmodule

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;
  localparam int DW = 72, AW = 4;
  localparam int T_ASR = 1, T_RAH = 1, T_ASC = 1, T_RCD = 2, T_RCD_MAX = 3, T_CAS = 2, T_CP = 1;
  localparam int T_CAP = 2, T_RP = 3, T_RAS_MIN = 6, T_RAS_MAX = 40, T_CSR = 2, T_CHR = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0, ref_ras_only = 1'b0;
  logic [AW-1:0] req_row = '0, req_col = '0, ref_row = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_grant, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out, dq_in;
  logic [AW-1:0] addr;

  always #5 clk = ~clk;

  edo_dram_ctrl #(.DW(DW), .AW(AW), .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_RCD(T_RCD),
    .T_RCD_MAX(T_RCD_MAX), .T_CAS(T_CAS), .T_CP(T_CP), .T_CAP(T_CAP), .T_RP(T_RP),
    .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_CSR(T_CSR), .T_CHR(T_CHR)) i_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_ras_only(ref_ras_only), .ref_row(ref_row), .ref_grant(ref_grant),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in));

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] shadow [0:255];
  logic [DW-1:0] exp_q [$];
  logic [AW-1:0] act_row = '0, cur_col = '0;

  assign dq_in = (!oe_n && !cas_n) ? mem[{act_row, cur_col}] : {9{8'hEE}};

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // memory model and strobe-spacing monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  int ras_hi = 100, ras_lo = 0, cas_hi = 100, cas_lo = 0, addr_same = 0;
  int cas_falls = 0, page_hits = 0, acts = 0, cbr_cnt = 0, ror_cnt = 0;
  bit act_cbr = 1'b0, moved = 1'b0;
  logic [AW-1:0] ror_row_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      int same_now, ras_lo_new;
      same_now   = (addr == prev_addr) ? addr_same + 1 : 0;
      ras_lo_new = !ras_n ? ras_lo + 1 : 0;
      if (prev_ras && !ras_n) begin
        acts++;
        chk(ras_hi >= T_RP, "R4 precharge", DW'(ras_hi), DW'(T_RP));
        if (!cas_n) begin
          act_cbr = 1'b1;
          chk(cas_lo >= T_CSR, "R9 cas setup", DW'(cas_lo), DW'(T_CSR));
          chk(we_n, "R9 we high", DW'(we_n), 1);
        end else begin
          act_cbr = 1'b0;
          chk(same_now >= T_ASR, "R2 row setup", DW'(same_now), DW'(T_ASR));
          act_row = addr;
        end
        moved = 1'b0;
        cas_falls = 0;
      end
      if (!ras_n && !act_cbr) begin
        if (ras_lo_new <= T_RAH) chk(addr == act_row, "R2 row hold", DW'(addr), DW'(act_row));
        if (addr != act_row) moved = 1'b1;
      end
      if (!prev_ras && !ras_n && prev_cas && !cas_n) begin
        if (cas_falls == 0) begin
          chk(ras_lo_new - 1 >= T_RCD && ras_lo_new - 1 <= T_RCD_MAX, "R3 ras-to-cas",
              DW'(ras_lo_new - 1), DW'(T_RCD));
        end else begin
          page_hits++;
          chk(cas_hi >= T_CP, "R5 cas precharge", DW'(cas_hi), DW'(T_CP));
        end
        chk(same_now >= T_ASC, "R3 column setup", DW'(same_now), DW'(T_ASC));
        cur_col = addr;
        if (!we_n) begin
          chk(!prev_we, "R7 we before cas", DW'(prev_we), 0);
          chk(dq_oe, "R7 data driven", DW'(dq_oe), 1);
          mem[{act_row, addr}] = dq_out;
        end
        cas_falls++;
      end
      if (!ras_n && !prev_ras && !prev_cas && cas_n) begin
        if (act_cbr) chk(ras_lo_new - 1 >= T_CHR, "R9 cas hold", DW'(ras_lo_new - 1), DW'(T_CHR));
        else chk(cas_lo >= T_CAS, "R5 cas width", DW'(cas_lo), DW'(T_CAS));
      end
      if (!prev_ras && ras_n) begin
        chk(ras_lo >= T_RAS_MIN, "R4 ras width", DW'(ras_lo), DW'(T_RAS_MIN));
        chk(ras_lo <= T_RAS_MAX, "R12 ras limit", DW'(ras_lo), DW'(T_RAS_MAX));
        if (act_cbr) cbr_cnt++;
        else if (cas_falls == 0) begin
          ror_cnt++;
          ror_row_seen = act_row;
          chk(!moved, "R10 row held", DW'(moved), 0);
        end
      end
      if (!we_n) chk(oe_n, "R7 outputs quiet", DW'(oe_n), 1);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected read", rd_data, '0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R8 read data", rd_data, e);
        end
      end
      ras_hi = ras_n ? ras_hi + 1 : 0;
      ras_lo = ras_lo_new;
      cas_hi = cas_n ? cas_hi + 1 : 0;
      cas_lo = !cas_n ? cas_lo + 1 : 0;
      addr_same = same_now;
      prev_ras = ras_n;
      prev_cas = cas_n;
      prev_we = we_n;
      prev_addr = addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", DW'(cyc), 0);
      finish_run();
    end
  end

  function automatic logic [DW-1:0] pat(input int r, input int c, input int s);
    logic [15:0] p;
    p = {4'(r), 4'(c), 8'(s)};
    return {8'(s) ^ 8'hA5, {4{p}}};
  endfunction

  task automatic xfer(input bit wr, input int r, input int c, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_row = AW'(r); req_col = AW'(c); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (wr) shadow[{AW'(r), AW'(c)}] = d;
    else exp_q.push_back(shadow[{AW'(r), AW'(c)}]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic refresh(input bit ror, input int r);
    @(negedge clk);
    ref_req = 1'b1; ref_ras_only = ror; ref_row = AW'(r);
    #1;
    while (!ref_grant) begin @(negedge clk); #1; end
    @(negedge clk);
    ref_req = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes idle", DW'({ras_n, cas_n}), 3);
    chk(we_n && oe_n, "R1 we/oe idle", DW'({we_n, oe_n}), 3);
    chk(!dq_oe && !rd_valid, "R1 no drive", DW'({dq_oe, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready, "R1 ready", DW'(req_ready), 1);
    chk(ras_n, "R1 ras after reset", DW'(ras_n), 1);

    // same-row bursts over the whole array (R5, R7, R12)
    for (int r = 0; r < 4; r++) begin
      int a0;
      a0 = acts;
      for (int c = 0; c < 16; c++) xfer(1'b1, r, c, pat(r, c, 1));
      chk(acts - a0 >= 2, "R12 burst split", DW'(acts - a0), 2);
    end
    chk(page_hits > 0, "R5 page hits", DW'(page_hits), 1);

    // row changes on every access (R6, R8)
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 4; r++) xfer(1'b0, r, c, '0);
    // overwrite with row alternation, then page-order read
    for (int c = 0; c < 16; c += 3)
      for (int r = 3; r >= 0; r--) xfer(1'b1, r, c, pat(r, c, 7));
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++) xfer(1'b0, r, c, '0);

    // idle open row is closed by the limit (R5, R12)
    xfer(1'b1, 5, 3, pat(5, 3, 9));
    repeat (3) @(negedge clk);
    chk(!ras_n, "R5 row stays open", DW'(ras_n), 0);
    repeat (60) @(negedge clk);
    chk(ras_n, "R12 idle row closed", DW'(ras_n), 1);

    // refresh and host request together (R11)
    begin
      int c0;
      c0 = cbr_cnt;
      @(negedge clk);
      ref_req = 1'b1; ref_ras_only = 1'b0;
      req_valid = 1'b1; req_write = 1'b0; req_row = AW'(5); req_col = AW'(3);
      #1;
      chk(ref_grant && !req_ready, "R11 refresh first", DW'({ref_grant, req_ready}), 2);
      @(negedge clk);
      ref_req = 1'b0;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      exp_q.push_back(shadow[{AW'(5), AW'(3)}]);
      chk(cbr_cnt == c0 + 1, "R11 refresh done before request", DW'(cbr_cnt), DW'(c0 + 1));
      @(negedge clk);
      req_valid = 1'b0;
    end

    // refresh while a row is open (R11, R9)
    begin
      int c0;
      xfer(1'b1, 6, 8, pat(6, 8, 3));
      repeat (2) @(negedge clk);
      c0 = cbr_cnt;
      refresh(1'b0, 0);
      chk(cbr_cnt == c0 + 1, "R11 open row closed for refresh", DW'(cbr_cnt), DW'(c0 + 1));
      c0 = cbr_cnt;
      refresh(1'b0, 0);
      chk(cbr_cnt == c0 + 1, "R9 cbr refresh", DW'(cbr_cnt), DW'(c0 + 1));
    end

    // RAS-only refresh (R10)
    begin
      int c0;
      c0 = ror_cnt;
      refresh(1'b1, 9);
      chk(ror_cnt == c0 + 1, "R10 ras-only seen", DW'(ror_cnt), DW'(c0 + 1));
      chk(ror_row_seen == AW'(9), "R10 refreshed row", DW'(ror_row_seen), 9);
      c0 = ror_cnt;
      refresh(1'b1, 14);
      chk(ror_row_seen == AW'(14) && ror_cnt == c0 + 1, "R10 second row", DW'(ror_row_seen), 14);
    end

    xfer(1'b0, 6, 8, '0);
    xfer(1'b0, 5, 3, '0);
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads returned", DW'(exp_q.size()), 0);
    finish_run();
  end
endmodule